// File: doc/BRIEF.md
# Absolute-Encoder Synchronous Serial Slave

This block plays the encoder side of a synchronous serial position link. A master toggles a clock line and the block answers on a single data line. It sends a 24-bit position word, most significant bit first, with one bit for each clock from the master. The clock and data lines are asynchronous to the system clock, so the clock line passes through a two-stage synchroniser before its edges are detected.

A frame starts on the first falling clock edge. That edge takes a snapshot of the pending word. Each rising edge after it presents the next bit. When all bits have been sent, the master gives one more clock pulse to close the frame. On that pulse the line goes low and stays low, and it does not start on the next word. A retriggerable monoflop timer, set in system clocks, ends the frame when the clock line has been quiet long enough. The block then returns to idle, the line goes high again, and the shift logic is cleared. A frame that the master abandons part-way therefore cannot shift the next one out of place.

The host supplies new words through a parallel load port, for example from an SPI receiver. The port accepts a word only while the interface is idle.

Top module: `ssi_enc_slave`

## Requirements
- R1: During and after reset the data line is high and `idle_o` is high.
- R2: A load pulse on `load_valid_i` is accepted only while `idle_o` is high. A load during a frame is ignored, and the frame after it still carries the earlier word. A word loaded in the same cycle in which the first falling edge is recognised is the word that frame carries.
- R3: The first synchronised falling edge of `ssi_clk_i` while idle starts a frame. `idle_o` goes low, and the data line stays high until the first rising edge.
- R4: Rising edge k of a frame (k = 1..24) presents bit 24-k of the captured word, so the MSB comes first.
- R5: The 25th rising edge drives the data line low. The line stays low through any further clock pulses until the timeout, and no bit of a following word appears.
- R6: When no clock edge has been seen for `mono_cycles_i` system clocks during a frame, the block returns to idle with the data line high.
- R7: After a frame that was cut off before all bits were sent, the timeout re-aligns the block, so the next frame delivers the full word starting from its MSB.
- R8: Back-to-back frames without a new load carry the same word, with no shift from one frame to the next.
- R9: Every clock edge restarts the timeout. Gaps shorter than `mono_cycles_i` never end a frame early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ssi_clk_i | input | 1 | Serial clock from the master, asynchronous, idles high |
| load_valid_i | input | 1 | Strobe that offers a new position word |
| load_word_i | input | 24 | Position word offered by the host |
| mono_cycles_i | input | 16 | Monoflop timeout in system clocks |
| ssi_data_o | output | 1 | Serial data to the master |
| idle_o | output | 1 | High while no frame is in progress |

## Verification
Two functions can fall in the same cycle: a host load, and the recognition of the falling edge that opens a frame. The bench knows the synchroniser latency. It drops the serial clock and raises the load strobe exactly two system clocks later, so both events act on the same edge. It then expects the newly offered word, not the old one, to come out bit by bit. Load pulses placed in the middle of a frame check the other side of the same rule: the following frame must still carry the older word.

// File: rtl/ssi_pkg.sv
// Package: shared types for the synchronous serial encoder slave.
// Assumes: nothing beyond IEEE 1800-2017.
package ssi_pkg;

    // Frame phase: waiting, sending bits, or holding low after the last bit.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_TAIL  = 2'd2
    } ssi_phase_e;

endpackage

// File: rtl/ssi_edge_sync.sv
// Module: ssi_edge_sync
// Brings an asynchronous level into the clk domain through SYNC_STAGES
// flip-flops and reports single-cycle rise and fall pulses.
// Assumes: the input is slower than clk by enough that no pulse is shorter
// than two clk periods; the reset level matches the line's idle level.
module ssi_edge_sync #(
    parameter int   SYNC_STAGES = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Synchroniser stages plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {CHAIN_W{RESET_LEVEL}};
        else        chain <= {chain[CHAIN_W-2:0], async_i};
    end

    // Edge pulses compare the last synchronised stage with its history.
    always_comb begin
        rise_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
        fall_o = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
    end
endmodule

// File: rtl/ssi_mono_timer.sv
// Module: ssi_mono_timer
// Retriggerable monoflop. While active it counts system clocks since the
// last retrigger and raises expire_o once the count reaches limit_i.
// Assumes: the owner drops active_i in the cycle after expire_o.
module ssi_mono_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             retrig_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] quiet_cnt;
    logic [CNT_W:0]   next_cnt;

    // Quiet-time counter: clears on an edge or when idle, saturates at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                      quiet_cnt <= '0;
        else if (!active_i || retrig_i)  quiet_cnt <= '0;
        else if (!expire_o)              quiet_cnt <= quiet_cnt + 1'b1;
    end

    // Expiry once the next count would meet the limit with no edge present.
    always_comb begin
        next_cnt = {1'b0, quiet_cnt} + 1'b1;
        expire_o = active_i && !retrig_i && (next_cnt >= {1'b0, limit_i});
    end
endmodule

// File: rtl/ssi_shifter.sv
// Module: ssi_shifter
// Frame sequencer and output shift register. A start pulse captures the
// word; each rise pulse sends the next bit MSB first; the rise after the
// last bit parks the line low; clear_i returns to idle with the line high.
// Assumes: start_i only pulses while idle; clear_i only pulses while busy.
module ssi_shifter
    import ssi_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rise_i,
    input  logic              clear_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              data_o,
    output ssi_phase_e        phase_o,
    output logic [$clog2(WORD_W+2)-1:0] bit_cnt_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W);

    ssi_phase_e        phase;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              data_q;

    // Frame sequencing, bit counting and output register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            data_q  <= 1'b1;
        end else if (clear_i) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            data_q  <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        shreg   <= word_i;
                        bit_cnt <= '0;
                        phase   <= PH_SHIFT;
                    end
                end
                PH_SHIFT: begin
                    if (rise_i) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_CNT) begin
                            data_q <= 1'b0;
                            phase  <= PH_TAIL;
                        end else begin
                            data_q <= shreg[WORD_W-1];
                            shreg  <= {shreg[WORD_W-2:0], 1'b0};
                        end
                    end
                end
                default: begin
                    phase <= PH_TAIL;
                end
            endcase
        end
    end

    // Expose state to the top level.
    always_comb begin
        data_o    = data_q;
        phase_o   = phase;
        bit_cnt_o = bit_cnt;
    end
endmodule

// File: rtl/ssi_enc_slave.sv
// Module: ssi_enc_slave (top)
// Slave side of a synchronous serial absolute-encoder link: clock
// synchroniser, monoflop timeout, pending-word latch and shifter.
// Assumes: ssi_clk_i idles high and each level lasts at least three clk
// periods; mono_cycles_i is held steady during a frame.
module ssi_enc_slave
    import ssi_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ssi_clk_i,
    input  logic              load_valid_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic [CNT_W-1:0]  mono_cycles_i,
    output logic              ssi_data_o,
    output logic              idle_o
);
    localparam int BC_W = $clog2(WORD_W + 2);

    logic              clk_rise;
    logic              clk_fall;
    logic              expire;
    logic              frame_start;
    logic              busy;
    logic [WORD_W-1:0] hold_word;
    logic [WORD_W-1:0] capture_word;
    ssi_phase_e        phase;
    logic [BC_W-1:0]   bit_cnt;

    ssi_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES),
        .RESET_LEVEL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ssi_clk_i),
        .rise_o  (clk_rise),
        .fall_o  (clk_fall)
    );

    ssi_mono_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (busy),
        .retrig_i (clk_rise | clk_fall),
        .limit_i  (mono_cycles_i),
        .expire_o (expire)
    );

    ssi_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (frame_start),
        .rise_i    (clk_rise),
        .clear_i   (expire),
        .word_i    (capture_word),
        .data_o    (ssi_data_o),
        .phase_o   (phase),
        .bit_cnt_o (bit_cnt)
    );

    // Pending-word latch: accepts host words only between frames.
    always_ff @(posedge clk) begin
        if (!rst_n)                        hold_word <= '0;
        else if (load_valid_i && !busy)    hold_word <= load_word_i;
    end

    // Frame start and capture source; a coincident load is forwarded.
    always_comb begin
        busy         = (phase != PH_IDLE);
        idle_o       = !busy;
        frame_start  = clk_fall && !busy;
        capture_word = load_valid_i ? load_word_i : hold_word;
    end
endmodule

// File: rtl/ssi_enc_slave_chk.sv
// Module: ssi_enc_slave_chk
// Property checker for ssi_enc_slave, attached with bind below.
// Assumes: it sees the top's internal edge, expiry and latch signals.
module ssi_enc_slave_chk #(
    parameter int WORD_W = 24,
    parameter int BC_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idle,
    input logic              data,
    input logic              rise,
    input logic              fall,
    input logic              expire,
    input logic [WORD_W-1:0] hold,
    input logic [BC_W-1:0]   bit_cnt
);
    // R1: the line is high whenever no frame runs.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> data);

    // R2: the pending word cannot change during a frame.
    p_hold_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(hold));

    // R3: only a falling edge leaves idle.
    p_wake_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !fall) |=> idle);

    // R5: after the closing pulse the line stays low while busy.
    p_tail_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && bit_cnt == BC_W'(WORD_W + 1)) |-> !data);

    // R5: the bit counter never passes the closing pulse.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BC_W'(WORD_W + 1));

    // R6: expiry returns the block to idle on the next cycle.
    p_expire_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> idle);

    // R9: a clock edge seen during a frame keeps it alive.
    p_edge_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && (rise || fall)) |=> !idle);
endmodule

bind ssi_enc_slave ssi_enc_slave_chk #(
    .WORD_W (WORD_W),
    .BC_W   ($clog2(WORD_W + 2))
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (idle_o),
    .data    (ssi_data_o),
    .rise    (clk_rise),
    .fall    (clk_fall),
    .expire  (expire),
    .hold    (hold_word),
    .bit_cnt (bit_cnt)
);

// File: tb/ssi_enc_slave_bench.sv
// Bench for ssi_enc_slave: directed corner cases plus seeded random frames.
// Inputs change and outputs are sampled on the falling edge of clk.
module ssi_enc_slave_bench;
    localparam int WORD_W = 24;
    localparam int MONO   = 100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ssi_clk_i = 1'b1;
    logic              load_valid_i = 1'b0;
    logic [WORD_W-1:0] load_word_i = '0;
    logic [15:0]       mono_cycles_i = 16'(MONO);
    logic              ssi_data_o;
    logic              idle_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [WORD_W-1:0] model_hold = '0;

    ssi_enc_slave u_ssi_enc_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .ssi_clk_i     (ssi_clk_i),
        .load_valid_i  (load_valid_i),
        .load_word_i   (load_word_i),
        .mono_cycles_i (mono_cycles_i),
        .ssi_data_o    (ssi_data_o),
        .idle_o        (idle_o)
    );

    always #5 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Host load while idle: the model follows R2.
    task automatic host_load(input logic [WORD_W-1:0] w);
        load_valid_i = 1'b1;
        load_word_i  = w;
        if (idle_o) model_hold = w;
        step(1);
        load_valid_i = 1'b0;
    endtask

    // Bit expected on rise k (R4), or low after the last bit (R5).
    function automatic logic exp_bit(input logic [WORD_W-1:0] w, input int k);
        if (k <= WORD_W) return w[WORD_W-k];
        return 1'b0;
    endfunction

    // One frame of nrise rising edges; optional mid-frame or coincident load.
    task automatic run_frame(input logic [WORD_W-1:0] expw, input int nrise, input int half,
                             input int inj_k, input logic [WORD_W-1:0] inj_w,
                             input bit co_load, input logic [WORD_W-1:0] co_w);
        ssi_clk_i = 1'b0;
        if (co_load) begin
            step(2);
            load_valid_i = 1'b1;
            load_word_i  = co_w;
            model_hold   = co_w;
            step(1);
            load_valid_i = 1'b0;
            step(half - 3);
        end else begin
            step(half);
        end
        check("R3 line high before first rise", 32'(ssi_data_o), 32'd1);
        check("R3 frame busy", 32'(idle_o), 32'd0);
        for (int k = 1; k <= nrise; k++) begin
            ssi_clk_i = 1'b1;
            if (k == inj_k) begin
                load_valid_i = 1'b1;
                load_word_i  = inj_w;
                step(1);
                load_valid_i = 1'b0;
                step(half - 1);
            end else begin
                step(half);
            end
            check(k <= WORD_W ? "R4 bit order" : "R5 tail low",
                  32'(ssi_data_o), 32'(exp_bit(expw, k)));
            if (k < nrise) begin
                ssi_clk_i = 1'b0;
                step(half);
            end
        end
    endtask

    // After a completed frame: low before timeout, idle high after it.
    task automatic finish_full;
        step(20);
        check("R5 low before timeout", 32'(ssi_data_o), 32'd0);
        step(120);
        check("R6 idle after timeout", 32'(idle_o), 32'd1);
        check("R6 line high after timeout", 32'(ssi_data_o), 32'd1);
    endtask

    initial begin
        int wd = 0;
        while (wd < 190000) begin
            @(posedge clk);
            wd++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] w;
        logic [WORD_W-1:0] old_w;
        void'($urandom(32'h5EED_0017));
        step(3);
        check("R1 line high in reset", 32'(ssi_data_o), 32'd1);
        check("R1 idle in reset", 32'(idle_o), 32'd1);
        rst_n = 1'b1;
        step(3);
        check("R1 idle after reset", 32'(idle_o), 32'd1);

        // Basic frame and repeats (R4, R5, R6, R8).
        host_load(24'hA5C3_96);
        for (int r = 0; r < 3; r++) begin
            run_frame(model_hold, 25, 8, 0, '0, 1'b0, '0);
            finish_full();
        end

        // Extra clocks in the tail (R5).
        host_load(24'h81_0F_F0);
        run_frame(model_hold, 28, 6, 0, '0, 1'b0, '0);
        finish_full();

        // Interrupted frame then a clean one (R7).
        run_frame(model_hold, 9, 7, 0, '0, 1'b0, '0);
        step(150);
        check("R7 idle after cut frame", 32'(idle_o), 32'd1);
        run_frame(model_hold, 25, 7, 0, '0, 1'b0, '0);
        finish_full();

        // Load during a frame is ignored (R2).
        old_w = model_hold;
        run_frame(old_w, 25, 8, 7, 24'h123456, 1'b0, '0);
        finish_full();
        run_frame(old_w, 25, 8, 0, '0, 1'b0, '0);
        finish_full();

        // Load coinciding with the start edge is forwarded (R2).
        run_frame(24'h3C_5A_E1, 25, 9, 0, '0, 1'b1, 24'h3C_5A_E1);
        finish_full();

        // Slow clock with gaps below the limit (R9).
        host_load(24'hFEDCBA);
        run_frame(model_hold, 25, 60, 0, '0, 1'b0, '0);
        step(150);
        check("R9 idle after slow frame", 32'(idle_o), 32'd1);

        // Seeded random frames, some cut short.
        for (int i = 0; i < 12; i++) begin
            int half;
            int nr;
            w    = WORD_W'($urandom);
            half = 5 + int'($urandom % 16);
            host_load(w);
            if (($urandom % 3) == 0) begin
                nr = 1 + int'($urandom % 23);
                run_frame(model_hold, nr, half, 0, '0, 1'b0, '0);
                step(150);
                check("R7 idle after random cut", 32'(idle_o), 32'd1);
            end else begin
                run_frame(model_hold, 25, half, 0, '0, 1'b0, '0);
                finish_full();
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule